// File: doc/BRIEF.md
# Paged 24-Line Digital I/O Port

This block gives a register window three 8-bit digital ports: A, B and C. Port C is split into a low nibble and a high nibble. Together they make 24 lines. Each group has a direction bit in a setup register, and a global enable bit gates all output drivers. Writing a port loads its output latch. Reading a port returns the synchronized pin levels, whichever way the lines point.

The upper window offsets 0xC to 0xF are shared with a counter bank that lives outside this block. Bit 0 of the control register at offset 0x8 chooses which bank those offsets reach. While the counter page is selected, accesses to those offsets do not touch the port state. Reads are combinational from the current address. Writes take effect on the clock edge where `wr_en_i` is high.

Top module: `dio_bank_port`

## Requirements
- R1: After reset the page bit is 0 (counter page) and the setup register reads 0x9B. All output latches are 0 and no line is driven (`pin_oe_o` = 0).
- R2: A write to offset 0x8 loads `wdata_i[0]` into the page bit in either page: 1 selects the I/O page and 0 selects the counter page. Reading offset 0x8 returns `{7'b0, page}`.
- R3: In the I/O page, writes to 0xC, 0xD and 0xE load the latches of ports A, B and C, and a write to 0xF loads the setup register. Nothing changes in a cycle without `wr_en_i`.
- R4: Setup register fields: bit 4 sets port A direction, bit 1 port B, bit 0 port C low, and bit 3 port C high, with 1 meaning input. Bit 7 enables the function. A group drives its lines only when bit 7 is 1 and its direction bit is 0.
- R5: `pin_o` always shows the latches, and the latches keep their values across direction or enable changes.
- R6: Reading 0xC, 0xD or 0xE in the I/O page returns the port's pin levels after a two-flop synchronizer. A change on `pin_i` becomes visible on the second rising edge after it. Reading 0xF returns the setup register.
- R7: While the counter page is selected, writes to 0xC–0xF change no port state, and reads of 0xC–0xF return 0.
- R8: Lines 0–7 belong to port A, 8–15 to port B, 16–19 to port C low, and 20–23 to port C high. Port data bit k maps to the port's k-th line.
- R9: Offsets 0x0–0x7 and 0x9–0xB read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register window offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pin_i | input | 24 | Pin levels seen on the lines |
| pin_o | output | 24 | Output latch values |
| pin_oe_o | output | 24 | Per-line output enable |

## Verification
Some properties are checked on every cycle. State does not change without a write, or under a write while the counter page is selected. Output enables are forced low while the enable bit is clear. Each group's enables switch together. The synchronizer output equals the pin value from two edges earlier.

Other behaviour needs the bench's scenarios: the exact group-to-bit mapping of the setup register, latch retention across direction flips, the readback latency, and the reset value. In those scenarios a behavioural model tracks page, setup, latches and pin history, and is compared against every output each cycle.

// File: rtl/dio_bank_pkg.sv
package dio_bank_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned LINES    = 3 * PORT_W;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_PA   = 4'hC;
  localparam logic [ADDR_W-1:0] OFF_PB   = 4'hD;
  localparam logic [ADDR_W-1:0] OFF_PC   = 4'hE;
  localparam logic [ADDR_W-1:0] OFF_CFG  = 4'hF;
  localparam logic [7:0] CFG_RST = 8'h9B;
  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_DA   = 4;
  localparam int unsigned BIT_DB   = 1;
  localparam int unsigned BIT_DCL  = 0;
  localparam int unsigned BIT_DCH  = 3;

  typedef struct packed {
    logic [PORT_W-1:0] c;
    logic [PORT_W-1:0] b;
    logic [PORT_W-1:0] a;
  } port_lat_t;

  // direction bit that governs a line
  function automatic int unsigned dir_bit(int unsigned line);
    if (line < PORT_W)                 return BIT_DA;
    else if (line < 2 * PORT_W)        return BIT_DB;
    else if (line < 2 * PORT_W + PORT_W / 2) return BIT_DCL;
    else                               return BIT_DCH;
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  p_sync_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic              page_dio_o,
  output logic [7:0]        cfg_o,
  output port_lat_t         lat_o
);
  logic      page_q;
  logic [7:0] cfg_q;
  port_lat_t lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= 1'b0;
      cfg_q  <= CFG_RST;
      lat_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFF_CTRL) page_q <= wdata_i[0];
      else if (page_q) begin
        case (addr_i)
          OFF_PA:  lat_q.a <= wdata_i;
          OFF_PB:  lat_q.b <= wdata_i;
          OFF_PC:  lat_q.c <= wdata_i;
          OFF_CFG: cfg_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign page_dio_o = page_q;
  assign cfg_o      = cfg_q;
  assign lat_o      = lat_q;

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(cfg_q) && $stable(lat_q) && $stable(page_q)));

  p_ctr_page_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!page_q && addr_i >= OFF_PA) |=> ($stable(cfg_q) && $stable(lat_q)));
endmodule

// File: rtl/dio_pin_drive.sv
module dio_pin_drive
  import dio_bank_pkg::*;
(
  input  logic [7:0]       cfg_i,
  input  port_lat_t        lat_i,
  output logic [LINES-1:0] pin_o,
  output logic [LINES-1:0] pin_oe_o
);
  assign pin_o = lat_i;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam int unsigned DB = dir_bit(i);
    assign pin_oe_o[i] = cfg_i[BIT_EN] & ~cfg_i[DB];
  end
endmodule

// File: rtl/dio_bank_port.sv
module dio_bank_port
  import dio_bank_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   addr_i,
  input  logic         wr_en_i,
  input  logic [7:0]   wdata_i,
  output logic [7:0]   rdata_o,
  input  logic [23:0]  pin_i,
  output logic [23:0]  pin_o,
  output logic [23:0]  pin_oe_o
);
  logic             page_dio;
  logic [7:0]       cfg;
  port_lat_t        lat;
  logic [LINES-1:0] pin_sync;

  dio_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .page_dio_o (page_dio),
    .cfg_o      (cfg),
    .lat_o      (lat)
  );

  dio_sync #(.W(LINES)) u_sync (
    .clk_i, .rst_ni,
    .d_i (pin_i),
    .q_o (pin_sync)
  );

  dio_pin_drive u_drive (
    .cfg_i    (cfg),
    .lat_i    (lat),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_CTRL) rdata_o = {7'b0, page_dio};
    else if (page_dio) begin
      case (addr_i)
        OFF_PA:  rdata_o = pin_sync[PORT_W-1:0];
        OFF_PB:  rdata_o = pin_sync[2*PORT_W-1:PORT_W];
        OFF_PC:  rdata_o = pin_sync[3*PORT_W-1:2*PORT_W];
        OFF_CFG: rdata_o = cfg;
        default: rdata_o = '0;
      endcase
    end
  end

  p_oe_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg[BIT_EN] |-> (pin_oe_o == '0));

  p_grp_uniform_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o[7:0] == 8'h00 || pin_oe_o[7:0] == 8'hFF) &&
     (pin_oe_o[15:8] == 8'h00 || pin_oe_o[15:8] == 8'hFF) &&
     (pin_oe_o[19:16] == 4'h0 || pin_oe_o[19:16] == 4'hF) &&
     (pin_oe_o[23:20] == 4'h0 || pin_oe_o[23:20] == 4'hF)));
endmodule

// File: tb/sim_dio_bank_port.sv
module sim_dio_bank_port;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dio_bank_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  // behavioural reference
  bit          m_page;
  logic [7:0]  m_cfg;
  logic [23:0] m_lat;
  logic [23:0] m_hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_page = 0; m_cfg = 8'h9B; m_lat = '0;
      m_hist = '{24'h0, 24'h0};
    end else begin
      m_hist.push_back(pin_in);
      void'(m_hist.pop_front());
      if (wr_en) begin
        if (addr == 4'h8) m_page = wdata[0];
        else if (m_page) begin
          if (addr == 4'hC) m_lat[7:0] = wdata;
          else if (addr == 4'hD) m_lat[15:8] = wdata;
          else if (addr == 4'hE) m_lat[23:16] = wdata;
          else if (addr == 4'hF) m_cfg = wdata;
        end
      end
    end
  end

  function automatic logic [23:0] exp_oe(logic [7:0] c);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) begin
      int b;
      if (i < 8) b = 4; else if (i < 16) b = 1; else if (i < 20) b = 0; else b = 3;
      r[i] = c[7] && !c[b];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    logic [23:0] s = m_hist[0];
    if (a == 4'h8) return {7'b0, m_page};
    if (!m_page) return 8'h00;
    case (a)
      4'hC: return s[7:0];
      4'hD: return s[15:8];
      4'hE: return s[23:16];
      4'hF: return m_cfg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 pin_o", pin_out, m_lat);
      chk("R4 pin_oe", pin_oe, exp_oe(m_cfg));
      chk("R6 rdata", rdata, exp_rd(addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired (all requirements)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [7:0] exp);
    @(negedge clk); #1;
    addr = a; wr_en = 0;
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 oe reset", pin_oe, 24'h0);
    chk("R1 latch reset", pin_out, 24'h0);
    rd("R1 page reset", 4'h8, 8'h00);
    rd("R7 read cfg in counter page", 4'hF, 8'h00);
    wr(4'h8, 8'h01);
    rd("R2 page read", 4'h8, 8'h01);
    rd("R1 cfg reset", 4'hF, 8'h9B);
    wr(4'hC, 8'h5A); wr(4'hD, 8'hC3); wr(4'hE, 8'h7E);
    chk("R3 R8 latches", pin_out, 24'h7EC35A);
    chk("R4 inputs no drive", pin_oe, 24'h0);
    wr(4'hF, 8'h80);
    chk("R4 all out", pin_oe, 24'hFFFFFF);
    rd("R6 cfg readback", 4'hF, 8'h80);
    wr(4'hF, 8'h88);
    chk("R8 C high input", pin_oe, 24'h0FFFFF);
    wr(4'hF, 8'h91);
    chk("R8 A and C low input", pin_oe, 24'hF0FF00);
    wr(4'hF, 8'h82);
    chk("R4 B input", pin_oe, 24'hFF00FF);
    wr(4'hF, 8'h00);
    chk("R4 enable clear", pin_oe, 24'h0);
    chk("R5 latch kept", pin_out, 24'h7EC35A);
    // synchronizer latency
    @(negedge clk); #1;
    addr = 4'hC; pin_in = 24'hA1B2C3;
    @(negedge clk); #1;
    chk("R6 one edge not yet", rdata, 8'h00);
    @(negedge clk); #1;
    chk("R6 two edges A", rdata, 8'hC3);
    rd("R6 port B", 4'hD, 8'hB2);
    rd("R6 port C", 4'hE, 8'hA1);
    pin_in = 24'h0F00F0;
    repeat (2) @(negedge clk);
    rd("R8 C nibbles", 4'hE, 8'h0F);
    // counter page isolation
    wr(4'hF, 8'h80);
    wr(4'h8, 8'h00);
    rd("R7 read A in counter page", 4'hC, 8'h00);
    wr(4'hC, 8'h11); wr(4'hE, 8'h22); wr(4'hF, 8'h9B);
    chk("R7 latch untouched", pin_out, 24'h7EC35A);
    chk("R7 oe untouched", pin_oe, 24'hFFFFFF);
    wr(4'h8, 8'h03);
    rd("R2 page bit only", 4'h8, 8'h01);
    rd("R7 cfg untouched", 4'hF, 8'h80);
    // other offsets
    wr(4'h3, 8'hFF); wr(4'hA, 8'h55); wr(4'h0, 8'h12);
    rd("R9 offset 3", 4'h3, 8'h00);
    rd("R9 offset A", 4'hA, 8'h00);
    chk("R9 latch kept", pin_out, 24'h7EC35A);
    rd("R9 cfg kept", 4'hF, 8'h80);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule